// File: doc/BRIEF.md
# Dual-Tone Digit Qualifier

This block takes the raw output of a dual-tone keypad detector and turns it into a clean, debounced digit interface. The detector gives a tone-present flag and a 4-bit key code that may flicker. The block bridges short dropouts in the tone. It rejects bursts that are too short to be a key press. It drives the accepted code onto a digit bus a fixed time after tone onset. It raises a digit-present flag a further fixed time later. It holds that flag for a trailing delay after the tone stops.

All timing comes from a millisecond tick, divided down from the system clock (3580 cycles of a 3.579545 MHz clock by default). The acceptance delay, present delay, trailing release and dropout bridge are parameters counted in ticks. Their defaults are 39, 8, 28 and 2 ms. The digit bus is driven only while receive mode is selected. An external tri-state buffer uses `bus_oe` for this. Leaving receive mode returns the sequencer to idle.

The sequencer has five states:
- `ST_IDLE` waits for a held tone.
- `ST_QUALIFY` times the acceptance window.
- `ST_SHOW` has the code on the bus and waits out the present delay.
- `ST_PRESENT` raises the flag while the tone lasts.
- `ST_RELEASE` keeps the flag for the trailing delay.

The transitions are:
- idle→qualify on a held tone.
- qualify→qualify when the code changes. The timer restarts.
- qualify→show when acceptance expires. The code is latched.
- qualify/show→idle when the held tone is lost.
- show→present when the present delay expires.
- present→release when the held tone is lost.
- release→idle when the trailing delay expires.
- any state→idle when receive mode is off.

Top module: `dtmf_digit_qualifier`

## Requirements
- R1: All timers advance once per millisecond tick, and one tick occurs every CLK_PER_MS clock cycles.
- R2: A held tone that ends before LATCH_MS ticks of constant code leaves the bus and the present flag unchanged, so a 24 ms burst is rejected.
- R3: A gap in the raw tone spanning at most GAP_MS ticks is bridged and the tone counts as continuous. A gap of more ticks ends the held tone.
- R4: The accepted code appears on `digit_bus` on the LATCH_MS-th tick after the held tone starts (default 39 ms).
- R5: `digit_valid` rises on the PRESENT_MS-th tick after the code appears on the bus (default 8 ms). The bus does not change in that cycle.
- R6: After the held tone ends, `digit_valid` stays high for RELEASE_MS ticks and then falls (default 28 ms). A tone that returns during this window does not extend it or start a new digit.
- R7: A change of raw code during qualification restarts the acceptance timer with the new code. A change after acceptance is ignored, and the bus keeps its code while `digit_valid` is high.
- R8: `bus_oe` is high only while `rx_mode` is 1. With `rx_mode` 0, no digit is accepted, and `digit_valid` is 0 from the next cycle. The bus keeps its last code.
- R9: The 4-bit code passes through unaltered. Keys 1–9 are 0001–1001, 0 is 1010, * is 1011, # is 1100, A is 1101, B is 1110, C is 1111 and D is 0000.
- R10: After reset, `digit_bus` is 0000 and `digit_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 3.579545 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_mode | input | 1 | 1 selects tone-receive mode |
| tone_raw | input | 1 | Unfiltered tone-present flag from the detector |
| code_raw | input | 4 | Unfiltered key code from the detector |
| digit_bus | output | 4 | Latched accepted key code |
| bus_oe | output | 1 | Drive enable for the external digit bus buffer |
| digit_valid | output | 1 | Digit-present flag |

## Verification
The assertions assume that `rx_mode` and the raw detector inputs change only between clock edges. They also assume the raw code only matters while the raw tone flag is high. The stimulus changes every input on the falling clock edge. It holds tone and code steady for whole multiples of a millisecond, apart from deliberate sub-tick gaps. A gap of 12 cycles (at most two ticks) and a gap of 40 cycles (four ticks) fall on either side of the dropout bridge. The tick divisor is shortened to 10 cycles so that every timing window can be swept within the run.

// File: rtl/dtmf_qual_pkg.sv
package dtmf_qual_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUALIFY,
        ST_SHOW,
        ST_PRESENT,
        ST_RELEASE
    } qual_state_t;

endpackage

// File: rtl/dtmf_ms_tick.sv
module dtmf_ms_tick #(
    parameter int DIV = 3580
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PW'(1);
        end
    end

    assign tick = (phase_q == LAST);
endmodule

// File: rtl/dtmf_gap_bridge.sv
module dtmf_gap_bridge #(
    parameter int GAP_MS = 2,
    parameter int CW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          tone_raw,
    input  logic [CW-1:0] code_raw,
    output logic          tone_held,
    output logic [CW-1:0] code_held
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_held <= '0;
        end else if (tone_raw) begin
            code_held <= code_raw;
        end
    end

    generate
        if (GAP_MS == 0) begin : g_no_bridge
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tone_held <= 1'b0;
                end else begin
                    tone_held <= tone_raw;
                end
            end
            logic unused_tick;
            assign unused_tick = tick;
        end else begin : g_bridge
            localparam int GW = $clog2(GAP_MS + 1);
            localparam logic [GW-1:0] GAP_LIM = GW'(GAP_MS);
            logic [GW-1:0] gap_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tone_held <= 1'b0;
                    gap_q     <= '0;
                end else if (tone_raw) begin
                    tone_held <= 1'b1;
                    gap_q     <= '0;
                end else if (tick && tone_held) begin
                    if (gap_q == GAP_LIM) begin
                        tone_held <= 1'b0;
                        gap_q     <= '0;
                    end else begin
                        gap_q <= gap_q + GW'(1);
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/dtmf_tick_timer.sv
module dtmf_tick_timer #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [TW-1:0] target,
    output logic          done
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

    assign done = tick && (cnt_q == (target - TW'(1)));
endmodule

// File: rtl/dtmf_digit_qualifier.sv
module dtmf_digit_qualifier
    import dtmf_qual_pkg::*;
#(
    parameter int CLK_PER_MS = 3580,
    parameter int LATCH_MS   = 39,
    parameter int PRESENT_MS = 8,
    parameter int RELEASE_MS = 28,
    parameter int GAP_MS     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_mode,
    input  logic              tone_raw,
    input  logic [CODE_W-1:0] code_raw,
    output logic [CODE_W-1:0] digit_bus,
    output logic              bus_oe,
    output logic              digit_valid
);
    localparam int MAX_A  = (LATCH_MS > PRESENT_MS) ? LATCH_MS : PRESENT_MS;
    localparam int MAX_MS = (MAX_A > RELEASE_MS) ? MAX_A : RELEASE_MS;
    localparam int TW     = $clog2(MAX_MS + 1);

    logic              tick;
    logic              tone_f;
    logic [CODE_W-1:0] code_f;
    logic              tmr_clear;
    logic              tmr_done;
    logic [TW-1:0]     tmr_target;
    logic              restart;
    qual_state_t       state_q, state_d;
    logic [CODE_W-1:0] cand_q;

    dtmf_ms_tick #(.DIV(CLK_PER_MS)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    dtmf_gap_bridge #(.GAP_MS(GAP_MS), .CW(CODE_W)) u_bridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .tone_raw  (tone_raw),
        .code_raw  (code_raw),
        .tone_held (tone_f),
        .code_held (code_f)
    );

    dtmf_tick_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tmr_clear),
        .tick   (tick),
        .target (tmr_target),
        .done   (tmr_done)
    );

    always_comb begin
        unique case (state_q)
            ST_SHOW:    tmr_target = TW'(PRESENT_MS);
            ST_RELEASE: tmr_target = TW'(RELEASE_MS);
            default:    tmr_target = TW'(LATCH_MS);
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        restart = 1'b0;
        if (!rx_mode) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (tone_f) state_d = ST_QUALIFY;
                end
                ST_QUALIFY: begin
                    if (!tone_f)               state_d = ST_IDLE;
                    else if (code_f != cand_q) restart = 1'b1;
                    else if (tmr_done)         state_d = ST_SHOW;
                end
                ST_SHOW: begin
                    if (!tone_f)       state_d = ST_IDLE;
                    else if (tmr_done) state_d = ST_PRESENT;
                end
                ST_PRESENT: begin
                    if (!tone_f) state_d = ST_RELEASE;
                end
                ST_RELEASE: begin
                    if (tmr_done) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign tmr_clear = (state_d != state_q) || restart;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and candidate code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q      <= '0;
            digit_bus   <= '0;
            digit_valid <= 1'b0;
        end else begin
            if ((state_q == ST_IDLE && state_d == ST_QUALIFY) || restart) begin
                cand_q <= code_f;
            end
            if (state_q == ST_QUALIFY && state_d == ST_SHOW) begin
                digit_bus <= cand_q;
            end
            digit_valid <= (state_d == ST_PRESENT) || (state_d == ST_RELEASE);
        end
    end

    assign bus_oe = rx_mode;
endmodule

// File: rtl/dtmf_digit_qualifier_chk.sv
module dtmf_digit_qualifier_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_mode,
    input logic       tone_held,
    input logic [3:0] digit_bus,
    input logic       digit_valid
);
    // R2
    bus_needs_tone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(digit_bus) |-> $past(tone_held));

    // R5
    flag_after_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(digit_valid) |-> $stable(digit_bus));

    // R5
    flag_needs_tone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(digit_valid) |-> $past(tone_held));

    // R7
    bus_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_valid && $past(digit_valid)) |-> $stable(digit_bus));

    // R8
    rx_off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_mode |=> !digit_valid);
endmodule

bind dtmf_digit_qualifier dtmf_digit_qualifier_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_mode     (rx_mode),
    .tone_held   (tone_f),
    .digit_bus   (digit_bus),
    .digit_valid (digit_valid)
);

// File: tb/dtmf_digit_qualifier_bench.sv
module dtmf_digit_qualifier_bench;
    localparam int DIV = 10;
    localparam int LAT = 39;
    localparam int PRS = 8;
    localparam int REL = 28;
    localparam int GAP = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_mode = 1'b1;
    logic       tone_raw = 1'b0;
    logic [3:0] code_raw = 4'd0;
    logic [3:0] digit_bus;
    logic       bus_oe;
    logic       digit_valid;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    dtmf_digit_qualifier #(.CLK_PER_MS(DIV)) u_dtmf_digit_qualifier (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_mode     (rx_mode),
        .tone_raw    (tone_raw),
        .code_raw    (code_raw),
        .digit_bus   (digit_bus),
        .bus_oe      (bus_oe),
        .digit_valid (digit_valid)
    );

    // behavioural reference: phase names as integers
    int m_ph, m_gap, m_cnt, m_phase;   // m_phase: 0 wait,1 qualify,2 show,3 present,4 release
    bit m_tone, m_valid;
    logic [3:0] m_code, m_cand, m_bus;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_gap = 0; m_cnt = 0; m_phase = 0;
            m_tone = 0; m_valid = 0; m_code = 0; m_cand = 0; m_bus = 0;
        end else begin
            bit tk, nt, rs, fin;
            int np, tgt;
            logic [3:0] nc;
            tk = (m_ph == DIV - 1);               // R1 one tick per DIV cycles
            m_ph = tk ? 0 : m_ph + 1;
            nt = m_tone; nc = m_code;
            if (tone_raw) begin
                nt = 1; nc = code_raw; m_gap = 0;
            end else if (tk && m_tone) begin
                if (m_gap == GAP) begin nt = 0; m_gap = 0; end
                else m_gap = m_gap + 1;
            end
            tgt = (m_phase == 2) ? PRS : (m_phase == 4) ? REL : LAT;
            fin = tk && (m_cnt == tgt - 1);
            np = m_phase; rs = 0;
            if (!rx_mode) np = 0;
            else if (m_phase == 0) begin if (m_tone) np = 1; end
            else if (m_phase == 1) begin
                if (!m_tone) np = 0;
                else if (m_code != m_cand) rs = 1;
                else if (fin) np = 2;
            end
            else if (m_phase == 2) begin
                if (!m_tone) np = 0; else if (fin) np = 3;
            end
            else if (m_phase == 3) begin if (!m_tone) np = 4; end
            else begin if (fin) np = 0; end
            if ((m_phase == 0 && np == 1) || rs) m_cand = m_code;
            if (m_phase == 1 && np == 2) m_bus = m_cand;
            if (np != m_phase || rs) m_cnt = 0;
            else if (tk) m_cnt = m_cnt + 1;
            m_phase = np;
            m_valid = (np == 3) || (np == 4);
            m_tone = nt; m_code = nc;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(digit_bus == m_bus, "R1 R4 R7 R9 bus", digit_bus, m_bus);
            check(digit_valid == m_valid, "R2 R3 R5 R6 flag", digit_valid, m_valid);
            check(bus_oe == rx_mode, "R8 oe", bus_oe, rx_mode);
        end
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tone_on(input logic [3:0] c, input int ms);
        tone_raw = 1'b1; code_raw = c;
        idle_cycles(ms * DIV);
    endtask

    task automatic tone_off(input int n);
        tone_raw = 1'b0;
        idle_cycles(n);
    endtask

    initial begin
        idle_cycles(5);
        // R10 reset state
        check(digit_bus == 4'd0, "R10 bus", digit_bus, 0);
        check(digit_valid == 1'b0, "R10 flag", digit_valid, 0);
        rst_n = 1'b1;
        idle_cycles(7);

        // key 5 accepted
        tone_on(4'd5, 60);
        check(digit_bus == 4'd5, "R4", digit_bus, 5);
        check(digit_valid == 1'b1, "R5", digit_valid, 1);
        tone_off(50 * DIV);
        check(digit_valid == 1'b0, "R6", digit_valid, 0);

        // 24 ms burst rejected
        tone_on(4'd9, 24);
        tone_off(40 * DIV);
        check(digit_bus == 4'd5, "R2", digit_bus, 5);

        // short gap bridged: key #
        tone_on(4'd12, 30);
        tone_off(12);
        tone_on(4'd12, 40);
        check(digit_bus == 4'd12, "R3 bridged", digit_bus, 12);
        tone_off(50 * DIV);

        // long gap splits the tone: neither half accepted
        tone_on(4'd3, 30);
        tone_off(40);
        tone_on(4'd3, 30);
        tone_off(50 * DIV);
        check(digit_bus == 4'd12, "R3 split", digit_bus, 12);

        // code change during qualification restarts
        tone_on(4'd1, 20);
        tone_on(4'd7, 45);
        check(digit_bus == 4'd7, "R7 restart", digit_bus, 7);
        tone_off(50 * DIV);

        // code change after acceptance ignored
        tone_on(4'd14, 60);
        tone_on(4'd2, 20);
        check(digit_bus == 4'd14, "R7 ignore", digit_bus, 14);
        tone_off(50 * DIV);

        // key D encodes as 0000
        tone_on(4'd0, 60);
        check(digit_bus == 4'd0, "R9 key D", digit_bus, 0);
        check(digit_valid == 1'b1, "R9 flag", digit_valid, 1);

        // release window, tone back during it is ignored
        tone_off(20 * DIV);
        check(digit_valid == 1'b1, "R6 hold", digit_valid, 1);
        tone_on(4'd4, 5);
        tone_off(15 * DIV);
        check(digit_valid == 1'b0, "R6 end", digit_valid, 0);
        check(digit_bus == 4'd0, "R6 bus", digit_bus, 0);
        tone_off(30 * DIV);

        // receive mode off
        rx_mode = 1'b0;
        tone_on(4'd6, 60);
        check(bus_oe == 1'b0, "R8 oe", bus_oe, 0);
        check(digit_bus == 4'd0, "R8 no accept", digit_bus, 0);
        tone_off(30 * DIV);
        rx_mode = 1'b1;
        tone_on(4'd8, 55);
        check(digit_valid == 1'b1, "R8 pre", digit_valid, 1);
        rx_mode = 1'b0;
        idle_cycles(2);
        check(digit_valid == 1'b0, "R8 drop", digit_valid, 0);
        check(digit_bus == 4'd8, "R8 keep", digit_bus, 8);
        tone_off(20);
        rx_mode = 1'b1;
        idle_cycles(40 * DIV);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule